// File: doc/BRIEF.md
# Fast Clear Window Event Gate

This block sits between an input latch and an event buffer. Each event the latch captures is held for a programmable time window before it goes on to the buffer. An external fast-clear pulse that arrives while the window is open cancels the held event, and a discard pulse is raised instead of a commit. A copy-in-progress output, `cip`, is high for exactly as long as the window is open.

Fast-clear mode is off after reset. It is turned on by a strobe that a key-address access produces, and turned off by a second key strobe. Ordinary register writes do not change the mode. With the mode off, or with a window length of zero, every event is committed in the cycle after it arrives.

The window length is an 8-bit value counted in 100 ns ticks. A prescaler of `TICK_DIV` clock cycles makes each tick, and `TICK_DIV` must be chosen so that this is 100 ns at the clock in use.

Top module: `fcw_event_gate`

## Requirements
- R1: After reset, `commit_valid`, `discard`, `cip` and `overrun` are 0, fast-clear mode is off and the window length is 0.
- R2: With fast-clear mode off, an event sampled at clock edge E sets `commit_valid` for one cycle after edge E, with `commit_data` equal to the event data, and `cip` stays 0.
- R3: A `key_fc_on` strobe turns fast-clear mode on. A `key_fc_off` strobe turns it off. When both strobes arrive in the same cycle, the mode ends up off.
- R4: With the mode on and window length N > 0 (written through `win_wr`/`win_wdata`, 8 bits), an event accepted at edge E raises `cip` from edge E for exactly N*TICK_DIV cycles.
- R5: When the window closes without a fast clear, `commit_valid` is high for one cycle after edge E+N*TICK_DIV, with the data of the held event, in the same cycle that `cip` falls.
- R6: A `fast_clear` sampled high at an edge while `cip` is high gives a one-cycle `discard` after that edge. At the same edge `cip` drops, and no commit follows for that event.
- R7: A `fast_clear` sampled while `cip` is low has no effect: no discard and no commit.
- R8: With the mode on and a window length of 0, an event commits after the edge that samples it, and `cip` stays 0.
- R9: An event that arrives while `cip` is high is rejected. It sets the sticky `overrun` flag, which stays 1 until reset. It does not restart the window, so the held event still commits at E+N*TICK_DIV with its own data.
- R10: A fast clear sampled at the very edge on which the window would close wins: the result is a discard and not a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; TICK_DIV cycles make 100 ns |
| rst_n | input | 1 | Synchronous active-low reset |
| key_fc_on | input | 1 | Key-access strobe that turns fast-clear mode on |
| key_fc_off | input | 1 | Key-access strobe that turns fast-clear mode off |
| win_wr | input | 1 | Write strobe for the window-length register |
| win_wdata | input | 8 | Window length in 100 ns ticks |
| ev_valid | input | 1 | Latch has a new event this cycle |
| ev_data | input | EV_W | Latched event pattern |
| fast_clear | input | 1 | External fast-clear pulse, synchronous to clk |
| commit_valid | output | 1 | One-cycle pulse: event goes to the buffer |
| commit_data | output | EV_W | Data of the committed event |
| discard | output | 1 | One-cycle pulse: held event cancelled |
| cip | output | 1 | Copy in progress; high while the window is open |
| overrun | output | 1 | Sticky flag: an event arrived during an open window |

## Verification
The assertions assume that `fast_clear`, `ev_valid` and the key strobes are already synchronous to `clk`, and that a value sampled at one edge is a whole decision for that cycle. The mode and window-length properties also assume that `win_wr` does not change the length while a check window is being measured. The bench drives every input at the falling edge, so each input is stable across the rising edge that samples it. It writes the window length only while no window is open. It places its fast-clear pulses on exact cycle offsets from the event edge, including the closing edge itself, so that every outcome falls on a known cycle.

// File: rtl/fcw_pkg.sv
// Shared types for the fast-clear window event gate.
// Assumes an 8-bit window-length register counted in 100 ns ticks.
package fcw_pkg;
    localparam int WIN_W = 8;
    typedef logic [WIN_W-1:0] win_t;
endpackage

// File: rtl/fcw_ctrl_regs.sv
// Holds the fast-clear mode flag and the window-length register.
// Assumes key strobes are single-cycle pulses decoded elsewhere; off wins over on.
module fcw_ctrl_regs
    import fcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_fc_on,
    input  logic key_fc_off,
    input  logic win_wr,
    input  win_t win_wdata,
    output logic mode_en,
    output win_t win_len
);
    // Mode flag: set by the on key, cleared by the off key (off has priority).
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_en <= 1'b0;
        else if (key_fc_off)
            mode_en <= 1'b0;
        else if (key_fc_on)
            mode_en <= 1'b1;
    end

    // Window-length register: plain write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_len <= '0;
        else if (win_wr)
            win_len <= win_wdata;
    end

    // R3
    key_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_fc_off |=> !mode_en);
    // R3
    key_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_fc_on && !key_fc_off) |=> mode_en);
endmodule

// File: rtl/fcw_tick_gen.sv
// Prescaler that gives a one-cycle tick every DIV clock cycles.
// Assumes DIV cycles equal 100 ns; restart realigns the phase to a new window.
module fcw_tick_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            // Every cycle is a tick when the clock period is the tick.
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] pre;

            // Phase counter: wraps at LAST, zeroed on restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart)
                    pre <= '0;
                else if (pre == LAST)
                    pre <= '0;
                else
                    pre <= pre + 1'b1;
            end

            assign tick = (pre == LAST);

            // R4
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fcw_hold_unit.sv
// Holds one event through its fast-clear window, then commits or discards it.
// Assumes fast_clear and ev_valid are synchronous; only one event is held at a time.
module fcw_hold_unit
    import fcw_pkg::*;
#(
    parameter int EV_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_en,
    input  win_t            win_len,
    input  logic            tick,
    input  logic            ev_valid,
    input  logic [EV_W-1:0] ev_data,
    input  logic            fast_clear,
    output logic            start,
    output logic            busy,
    output logic            commit_valid,
    output logic [EV_W-1:0] commit_data,
    output logic            discard,
    output logic            overrun
);
    win_t            cnt;
    logic [EV_W-1:0] held;
    logic            use_window;

    assign use_window = mode_en && (win_len != '0);
    assign start      = ev_valid && !busy && use_window;

    // Window state: open, count ticks, close by commit or by fast clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            cnt          <= '0;
            held         <= '0;
            commit_valid <= 1'b0;
            commit_data  <= '0;
            discard      <= 1'b0;
        end else begin
            commit_valid <= 1'b0;
            discard      <= 1'b0;
            if (busy) begin
                if (fast_clear) begin
                    busy    <= 1'b0;
                    discard <= 1'b1;
                end else if (tick && cnt == win_t'(1)) begin
                    busy         <= 1'b0;
                    commit_valid <= 1'b1;
                    commit_data  <= held;
                end else if (tick) begin
                    cnt <= cnt - win_t'(1);
                end
            end else if (ev_valid) begin
                if (use_window) begin
                    busy <= 1'b1;
                    cnt  <= win_len;
                    held <= ev_data;
                end else begin
                    commit_valid <= 1'b1;
                    commit_data  <= ev_data;
                end
            end
        end
    end

    // Sticky overrun flag: an event while a window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (busy && ev_valid)
            overrun <= 1'b1;
    end

    // R2
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_en && !busy && ev_valid) |=> (commit_valid && !busy && commit_data == $past(ev_data)));
    // R5
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (commit_valid ^ discard));
    // R6
    discard_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> ($past(busy) && $past(fast_clear)));
    // R7
    idle_fc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fast_clear) |=> !discard);
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_valid && !tick && !fast_clear) |=> (busy && cnt == $past(cnt)));
    // R10
    fc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fast_clear) |=> (discard && !commit_valid));
endmodule

// File: rtl/fcw_event_gate.sv
// Top: gates each latched event through a programmable fast-clear window.
// Assumes TICK_DIV clock cycles equal 100 ns; bus decode and FIFO lie outside.
module fcw_event_gate #(
    parameter int EV_W     = 32,
    parameter int TICK_DIV = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_fc_on,
    input  logic            key_fc_off,
    input  logic            win_wr,
    input  logic [7:0]      win_wdata,
    input  logic            ev_valid,
    input  logic [EV_W-1:0] ev_data,
    input  logic            fast_clear,
    output logic            commit_valid,
    output logic [EV_W-1:0] commit_data,
    output logic            discard,
    output logic            cip,
    output logic            overrun
);
    import fcw_pkg::*;

    logic mode_en;
    win_t win_len;
    logic tick;
    logic start;
    logic busy;

    fcw_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_fc_on  (key_fc_on),
        .key_fc_off (key_fc_off),
        .win_wr     (win_wr),
        .win_wdata  (win_wdata),
        .mode_en    (mode_en),
        .win_len    (win_len)
    );

    fcw_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .tick    (tick)
    );

    fcw_hold_unit #(.EV_W(EV_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_en      (mode_en),
        .win_len      (win_len),
        .tick         (tick),
        .ev_valid     (ev_valid),
        .ev_data      (ev_data),
        .fast_clear   (fast_clear),
        .start        (start),
        .busy         (busy),
        .commit_valid (commit_valid),
        .commit_data  (commit_data),
        .discard      (discard),
        .overrun      (overrun)
    );

    assign cip = busy;

    // R1
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!cip && !commit_valid && !discard && !overrun));
endmodule

// File: tb/fcw_event_gate_test.sv
module fcw_event_gate_test;
    localparam int EV_W = 32;
    localparam int DIV  = 4;
    localparam int WIN  = 3;
    localparam int SPAN = WIN * DIV;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            key_fc_on = 1'b0, key_fc_off = 1'b0, win_wr = 1'b0;
    logic [7:0]      win_wdata = '0;
    logic            ev_valid = 1'b0;
    logic [EV_W-1:0] ev_data = '0;
    logic            fast_clear = 1'b0;
    logic            commit_valid, discard, cip, overrun;
    logic [EV_W-1:0] commit_data;

    fcw_event_gate #(.EV_W(EV_W), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .key_fc_on(key_fc_on), .key_fc_off(key_fc_off),
        .win_wr(win_wr), .win_wdata(win_wdata), .ev_valid(ev_valid), .ev_data(ev_data),
        .fast_clear(fast_clear), .commit_valid(commit_valid), .commit_data(commit_data),
        .discard(discard), .cip(cip), .overrun(overrun)
    );

    always #4ns clk = ~clk;   // 125 MHz

    typedef struct {
        bit              is_commit;
        logic [EV_W-1:0] data;
        int              cyc;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design produces a result.
    always @(negedge clk) begin
        if (rst_n && (commit_valid || discard)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7", "unexpected output", {commit_valid, discard}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(commit_valid == e.is_commit && discard == !e.is_commit, e.tag,
                    "kind commit/discard", {commit_valid, discard}, {e.is_commit, !e.is_commit});
                chk(cyc == e.cyc, e.tag, "cycle", cyc, e.cyc);
                if (e.is_commit)
                    chk(commit_data == e.data, e.tag, "data", commit_data, e.data);
            end
        end
    end

    task automatic push(input bit is_commit, input logic [EV_W-1:0] d,
                        input int at, input string tag);
        exp_t e;
        e.is_commit = is_commit; e.data = d; e.cyc = at; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: one event pulse; returns the sampling edge number.
    task automatic send_ev(input logic [EV_W-1:0] d, output int edge_no);
        @(negedge clk);
        ev_valid = 1'b1; ev_data = d; edge_no = cyc + 1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic pulse_fc(output int edge_no);
        @(negedge clk);
        fast_clear = 1'b1; edge_no = cyc + 1;
        @(negedge clk);
        fast_clear = 1'b0;
    endtask

    task automatic set_win(input logic [7:0] n);
        @(negedge clk); win_wr = 1'b1; win_wdata = n;
        @(negedge clk); win_wr = 1'b0;
    endtask

    task automatic keys(input bit on, input bit off);
        @(negedge clk); key_fc_on = on; key_fc_off = off;
        @(negedge clk); key_fc_on = 1'b0; key_fc_off = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e, f, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!commit_valid && !discard && !cip && !overrun, "R1", "outputs in reset",
            {commit_valid, discard, cip, overrun}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!cip && !overrun, "R1", "outputs after reset", {cip, overrun}, 0);

        // R2 mode off: immediate commit
        set_win(8'(WIN));
        send_ev(32'hA5A5_0001, e); push(1, 32'hA5A5_0001, e, "R2");
        chk(!cip, "R2", "cip with mode off", cip, 0);

        // R3 on and off together leaves mode off
        keys(1, 1);
        send_ev(32'h0000_0302, e); push(1, 32'h0000_0302, e, "R3");
        chk(!cip, "R3", "cip after on+off", cip, 0);

        // R8 mode on, window 0
        set_win(8'd0);
        keys(1, 0);
        send_ev(32'h0000_0808, e); push(1, 32'h0000_0808, e, "R8");
        chk(!cip, "R8", "cip with zero window", cip, 0);

        // R4 / R5 full window then commit
        set_win(8'(WIN));
        send_ev(32'hC0FF_EE04, e); push(1, 32'hC0FF_EE04, e + SPAN, "R5");
        n = 0;
        while (cip && n < 1000) begin n++; @(negedge clk); end
        chk(n == SPAN, "R4", "cip length", n, SPAN);
        repeat (2) @(negedge clk);

        // R6 fast clear mid-window
        send_ev(32'h0000_0606, e);
        repeat (3) @(negedge clk);
        pulse_fc(f); push(0, '0, f, "R6");
        chk(!cip, "R6", "cip after fast clear", cip, 0);
        repeat (SPAN + 2) @(negedge clk);

        // R7 fast clear with no window open (monitor flags any output)
        pulse_fc(f);
        repeat (3) @(negedge clk);
        chk(!discard && !commit_valid && !cip, "R7", "idle fast clear",
            {discard, commit_valid, cip}, 0);

        // R10 fast clear on the closing edge
        send_ev(32'h0000_1010, e);
        repeat (SPAN - 2) @(negedge clk);
        pulse_fc(f);
        chk(f == e + SPAN, "R10", "pulse placement", f, e + SPAN);
        push(0, '0, f, "R10");
        repeat (3) @(negedge clk);

        // R9 event during open window: rejected, sticky overrun, no restart
        chk(!overrun, "R9", "overrun before", overrun, 0);
        send_ev(32'h0000_0909, e); push(1, 32'h0000_0909, e + SPAN, "R9");
        repeat (2) @(negedge clk);
        send_ev(32'hDEAD_0009, f);
        chk(overrun, "R9", "overrun set", overrun, 1);
        repeat (SPAN + 3) @(negedge clk);
        chk(overrun && !cip, "R9", "overrun sticky / window closed", {overrun, cip}, 2'b10);

        // R3 off key returns to immediate commit
        keys(0, 1);
        send_ev(32'h0000_0F0F, e); push(1, 32'h0000_0F0F, e, "R3");
        chk(!cip, "R3", "cip after off key", cip, 0);

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R5", "scoreboard drained", q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule